// File: doc/BRIEF.md
# Stale Data Timer with Two-Stage Prescaler

This block watches a receive FIFO and raises a flag when data has been sitting in it with no new byte arriving for a programmable time. Time is measured by a base prescaler that produces a slow tick from the system clock. A divide-by-ten stage follows it, and that stage drives a saturating stale counter. Two test bits shorten the prescaler stages independently, so a bench or a system test can reach a timeout in a few clocks instead of milliseconds.

When the stale counter reaches the terminal count, a timeout status latch is set. A masked stale status and two interrupt requests are derived from the timeout and from the stale condition. A mask bit suppresses the stale status and both interrupt requests. A clear bit holds the timeout latch clear for as long as it stays set.

Top module: `stale_timer`

## Requirements
- R1: With both shorten bits clear, the base prescaler ticks once every 250 clocks and the stale counter advances once every 10 base ticks. With terminal count T, `stale_stat` goes high T*2500+1 clock edges after the last edge that sampled a restart.
- R2: With `shrt_tick` set, the base tick period is 2 clocks instead of 250. `stale_stat` goes high T*20+1 edges after the restart.
- R3: With `shrt_stale` set, the divide-by-ten stage is bypassed and the counter advances on every base tick. `stale_stat` goes high T*250+1 edges after the restart.
- R4: With both shorten bits set, the counter advances every other clock. `stale_stat` goes high 2*T+1 edges after the restart.
- R5: A restart is a clock edge that samples `fifo_wr` high or `fifo_nempty` low. A restart zeroes both prescalers and the counter. While it is sampled, the stale condition is false, so `stale_stat` is low after the following edge.
- R6: The counter saturates at the terminal count. Once set, `tmo_stat` stays high through restarts until it is cleared.
- R7: While `clr_tmo` is sampled high, `tmo_stat` is low after the next edge. `onechar_irq` is low after any edge that sampled `clr_tmo` high.
- R8: `stale_stat` and `stale_irq` both equal the registered stale condition ANDed with the inverse of `stale_off`. `stale_off` also suppresses `onechar_irq`.
- R9: `onechar_irq` is the registered AND of the timeout latch, `fifo_nempty`, the inverse of `stale_off` and the inverse of `clr_tmo`.
- R10: Synchronous reset drives all four outputs low. A terminal count of zero never produces a stale condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| fifo_wr | input | 1 | FIFO write strobe; restarts timing |
| fifo_nempty | input | 1 | FIFO holds at least one byte |
| shrt_tick | input | 1 | Shorten base prescaler to 2 clocks |
| shrt_stale | input | 1 | Bypass divide-by-ten stage |
| stale_off | input | 1 | Mask stale status and both interrupts |
| clr_tmo | input | 1 | Hold timeout latch clear |
| term_cnt | input | CNT_W | Stale counter terminal count |
| tmo_stat | output | 1 | Latched timeout status |
| stale_stat | output | 1 | Masked stale status |
| stale_irq | output | 1 | Stale interrupt request |
| onechar_irq | output | 1 | One-character interrupt request |

## Verification
The assertions assume that every input is a synchronous level that stays stable between clock edges. They also assume that the control bits and the terminal count can change on any cycle without harming correctness. The bench drives all inputs on the falling edge. Its random phase changes the control bits and the terminal count freely, keeping the terminal count small and both shorten bits mostly set, so that timeouts occur often within the run. The directed phase holds the controls fixed over each measured interval, so every measured delay reflects a single mode.

// File: rtl/stale_timer.sv
module stale_timer #(
  parameter int BASE_DIV  = 250,
  parameter int SHORT_DIV = 2,
  parameter int STALE_DIV = 10,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_wr,
  input  logic             fifo_nempty,
  input  logic             shrt_tick,
  input  logic             shrt_stale,
  input  logic             stale_off,
  input  logic             clr_tmo,
  input  logic [CNT_W-1:0] term_cnt,
  output logic             tmo_stat,
  output logic             stale_stat,
  output logic             stale_irq,
  output logic             onechar_irq
);
  localparam int PW = $clog2(BASE_DIV);
  localparam int DW = $clog2(STALE_DIV);
  localparam logic [PW-1:0] BASE_LAST  = PW'(BASE_DIV - 1);
  localparam logic [PW-1:0] SHORT_LAST = PW'(SHORT_DIV - 1);
  localparam logic [DW-1:0] DIV_LAST   = DW'(STALE_DIV - 1);

  logic [PW-1:0]    pre_q;
  logic [DW-1:0]    div_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tmo_q, stale_q, sirq_q, onec_q;

  wire restart = fifo_wr | ~fifo_nempty;
  wire [PW-1:0] pre_last = shrt_tick ? SHORT_LAST : BASE_LAST;
  wire base_tick  = ~restart & (pre_q >= pre_last);
  wire advance    = base_tick & (shrt_stale | (div_q >= DIV_LAST));
  wire at_term    = cnt_q >= term_cnt;
  wire stale_cond = ~restart & (|term_cnt) & at_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      div_q   <= '0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
      stale_q <= 1'b0;
      sirq_q  <= 1'b0;
      onec_q  <= 1'b0;
    end else begin
      pre_q <= (restart | base_tick) ? '0 : pre_q + 1'b1;
      if (restart | shrt_stale)
        div_q <= '0;
      else if (base_tick)
        div_q <= (div_q >= DIV_LAST) ? '0 : div_q + 1'b1;
      if (restart)
        cnt_q <= '0;
      else if (advance & ~at_term)
        cnt_q <= cnt_q + 1'b1;
      tmo_q   <= ~clr_tmo & (tmo_q | stale_cond);
      stale_q <= stale_cond & ~stale_off;
      sirq_q  <= stale_cond & ~stale_off;
      onec_q  <= tmo_q & fifo_nempty & ~stale_off & ~clr_tmo;
    end
  end

  assign tmo_stat    = tmo_q;
  assign stale_stat  = stale_q;
  assign stale_irq   = sirq_q;
  assign onechar_irq = onec_q;
endmodule

// File: rtl/stale_timer_chk.sv
module stale_timer_chk #(parameter int CNT_W = 8) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_wr,
  input logic             fifo_nempty,
  input logic             stale_off,
  input logic             clr_tmo,
  input logic [CNT_W-1:0] term_cnt,
  input logic             tmo_stat,
  input logic             stale_stat,
  input logic             stale_irq,
  input logic             onechar_irq
);
  AST_CLR_HOLDS_TMO: assert property (@(posedge clk) disable iff (rst)
    clr_tmo |=> !tmo_stat); // R7
  AST_CLR_BLOCKS_ONECHAR: assert property (@(posedge clk) disable iff (rst)
    clr_tmo |=> !onechar_irq); // R7
  AST_MASK_STALE: assert property (@(posedge clk) disable iff (rst)
    stale_off |=> (!stale_stat && !stale_irq && !onechar_irq)); // R8
  AST_ONECHAR_NEEDS_TMO: assert property (@(posedge clk) disable iff (rst)
    onechar_irq |-> $past(tmo_stat)); // R9
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tmo_stat && !clr_tmo) |=> tmo_stat); // R6
  AST_RESTART_DROPS_STALE: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr || !fifo_nempty) |=> !stale_stat); // R5
  AST_ZERO_TERM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (term_cnt == '0) |=> !stale_irq); // R10
endmodule

bind stale_timer stale_timer_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/stale_timer_tb.sv
module stale_timer_tb_top;
  logic clk = 0, rst = 1;
  logic fifo_wr = 0, fifo_nempty = 0, shrt_tick = 0, shrt_stale = 0;
  logic stale_off = 0, clr_tmo = 0;
  logic [7:0] term_cnt = 0;
  logic tmo_stat, stale_stat, stale_irq, onechar_irq;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  stale_timer dut_i (.clk, .rst, .fifo_wr, .fifo_nempty, .shrt_tick, .shrt_stale,
    .stale_off, .clr_tmo, .term_cnt, .tmo_stat, .stale_stat, .stale_irq, .onechar_irq);

  int m_p, m_d, m_s;
  logic m_tmo, m_stale, m_one;
  always @(posedge clk) begin
    automatic bit rs = fifo_wr || !fifo_nempty;
    automatic int lim = shrt_tick ? 2 : 250;
    automatic bit tick = !rs && (m_p >= lim - 1);
    automatic bit adv = tick && (shrt_stale || m_d == 9);
    automatic bit cond = !rs && term_cnt != 0 && m_s >= term_cnt;
    if (rst) begin
      m_p <= 0; m_d <= 0; m_s <= 0; m_tmo <= 0; m_stale <= 0; m_one <= 0;
    end else begin
      m_p <= (rs || tick) ? 0 : m_p + 1;
      m_d <= (rs || shrt_stale) ? 0 : (tick ? (m_d == 9 ? 0 : m_d + 1) : m_d);
      m_s <= rs ? 0 : ((adv && m_s < term_cnt) ? m_s + 1 : m_s);
      m_tmo <= !clr_tmo && (m_tmo || cond);
      m_stale <= cond && !stale_off;
      m_one <= m_tmo && fifo_nempty && !stale_off && !clr_tmo;
    end
  end

  function automatic int expect_edges(int t, bit st, bit ss);
    return t * (st ? 2 : 250) * (ss ? 1 : 10) + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(string req, int t, bit st, bit ss);
    int n = 0;
    shrt_tick = st; shrt_stale = ss; term_cnt = 8'(t); fifo_nempty = 1; fifo_wr = 1;
    @(negedge clk); fifo_wr = 0;
    while (!stale_stat && n < 30000) begin @(negedge clk); n++; end
    chk(req, n, expect_edges(t, st, ss));
  endtask

  initial begin
    fork
      begin
        repeat (199000) @(negedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        chk("R10 tmo", tmo_stat, 0); chk("R10 stale", stale_stat, 0);
        chk("R10 sirq", stale_irq, 0); chk("R10 onechar", onechar_irq, 0);
        rst = 0;
        @(negedge clk); clr_tmo = 1; @(negedge clk); clr_tmo = 0;
        measure("R1", 1, 0, 0);
        measure("R2", 3, 1, 0);
        measure("R3", 2, 0, 1);
        measure("R4", 5, 1, 1);
        chk("R8 irq follows stat", stale_irq, 1);
        chk("R6 tmo set", tmo_stat, 1);
        @(negedge clk);
        chk("R9 onechar", onechar_irq, 1);
        repeat (20) @(negedge clk);
        chk("R6 saturate hold", stale_stat, 1);
        fifo_wr = 1; @(negedge clk); fifo_wr = 0;
        chk("R5 restart drops stale", stale_stat, 0);
        chk("R6 tmo sticky", tmo_stat, 1);
        fifo_nempty = 0; @(negedge clk);
        chk("R9 empty kills onechar", onechar_irq, 0);
        chk("R5 empty no stale", stale_stat, 0);
        repeat (30) @(negedge clk);
        chk("R5 empty stays quiet", stale_stat, 0);
        fifo_nempty = 1; clr_tmo = 1;
        @(negedge clk);
        chk("R7 tmo cleared", tmo_stat, 0);
        repeat (20) @(negedge clk);
        chk("R7 stale still flags", stale_stat, 1);
        chk("R7 tmo held", tmo_stat, 0);
        chk("R7 onechar held", onechar_irq, 0);
        clr_tmo = 0; @(negedge clk); @(negedge clk);
        chk("R7 tmo after release", tmo_stat, 1);
        stale_off = 1; @(negedge clk); @(negedge clk);
        chk("R8 stat masked", stale_stat, 0);
        chk("R8 irq masked", stale_irq, 0);
        chk("R8 onechar masked", onechar_irq, 0);
        stale_off = 0; clr_tmo = 1; term_cnt = 0; fifo_wr = 1;
        @(negedge clk); fifo_wr = 0; clr_tmo = 0;
        repeat (100) @(negedge clk);
        chk("R10 zero term", stale_stat, 0);
        chk("R10 zero term tmo", tmo_stat, 0);
        for (int i = 0; i < 4000; i++) begin
          fifo_wr = ($urandom % 16) == 0;
          fifo_nempty = ($urandom % 20) != 0;
          if ($urandom % 50 == 0) shrt_tick = ($urandom % 8) != 0;
          if ($urandom % 50 == 0) shrt_stale = ($urandom % 8) != 0;
          stale_off = ($urandom % 25) == 0;
          clr_tmo = ($urandom % 40) == 0;
          if ($urandom % 100 == 0) term_cnt = 8'($urandom % 5);
          @(negedge clk);
          chk("R6 tmo model", tmo_stat, m_tmo);
          chk("R8 stale model", stale_stat, m_stale);
          chk("R8 irq model", stale_irq, m_stale);
          chk("R9 onechar model", onechar_irq, m_one);
        end
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule